// File: doc/BRIEF.md
# Dual-Port Segment Privacy Controller

This block sits beside a memory array that two hosts share: a system bus and a private local bus. The array is cut into four equal segments. For every system bus request that lands in the board's memory window, the block decides whether to let the access through or to refuse it. A refused access can be answered with a bus error strobe, or it can be left unanswered so that the requester's own timeout handles it. Accesses from the local port are never gated.

An 8-bit control/status register chooses which segments are reserved for the local port. It is read and written from the system bus with the short supervisory I/O address modifier (0x15) at a short address set by a strap input. The same register holds a sticky parity-error flag that hardware sets, diagnostic controls that are passed out to the datapath, and an active-low control that lets the local port mark its accesses as cacheable.

Every decision is registered. A request sampled at a rising clock edge gets its answer on the outputs for exactly one cycle after that edge.

Top module: `seg_privacy_ctrl`

## Requirements
- R1: After a synchronous reset all eight control bits read as 0. With the range field at 00, all four segments are then local-only, so a memory access gets neither grant nor bus error.
- R2: A request with `sys_am` = 0x15 whose `sys_addr[15:0]` equals `csr_addr` selects the register. A write stores all 8 bits of `sys_wdata`. A read returns the register on `csr_rdata`. Both pulse `csr_ack` for one cycle after the request edge. Any other modifier or short address leaves the register unchanged and gives no `csr_ack`.
- R3: When bit 6 (private-all) is set, every in-window memory access is refused.
- R4: When bit 6 is clear, bits 5:4 hold a value P. Segment S, taken from `sys_addr[19:18]`, is local-only when S >= P and shared when S < P. A shared access pulses `sys_grant` for one cycle after the request edge.
- R5: While bit 6 is set, the value of bits 5:4 has no effect on the decision.
- R6: A refused access with bit 3 (bus-error enable) set pulses `sys_berr` for one cycle after the request edge, with `sys_grant` low.
- R7: A refused access with bit 3 clear raises neither `sys_grant` nor `sys_berr`.
- R8: A memory request whose `sys_addr[31:20]` differs from `win_base`, and any register-modifier request, produces neither `sys_grant` nor `sys_berr`.
- R9: A high `par_err_in` sets bit 7 at the next edge, and that wins over a write in the same cycle. A register write can set or clear bit 7.
- R10: `loc_cache_n` is low exactly when `loc_ack` is high and bit 2 is clear.
- R11: `wrong_par` follows bit 1 and `par_rep_en` follows bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_req | input | 1 | One-cycle system bus request strobe |
| sys_am | input | 6 | System bus address modifier |
| sys_addr | input | 32 | System bus address |
| sys_write | input | 1 | 1 = write, 0 = read |
| sys_wdata | input | 8 | Register write data |
| win_base | input | 12 | Memory window base (upper address bits) |
| csr_addr | input | 16 | Short I/O address of the register |
| par_err_in | input | 1 | Parity error detected on a read |
| loc_ack | input | 1 | Local port access acknowledge |
| sys_grant | output | 1 | Memory access allowed |
| sys_berr | output | 1 | Bus error strobe for a refused access |
| csr_ack | output | 1 | Register access acknowledge |
| csr_rdata | output | 8 | Register read data |
| wrong_par | output | 1 | Write wrong parity (diagnostic) |
| par_rep_en | output | 1 | Parity error reporting enable |
| loc_cache_n | output | 1 | Active-low cacheable indication on local port |

## Verification
The main decision is driven from a table that pairs each range value with the segments on both sides of its boundary. Each threshold is therefore shown to move by exactly one segment. Each pair is repeated with the bus-error enable on and off, which separates a loud refusal from a silent one. Rows with private-all set carry range values that would otherwise grant, so they show that the range field is ignored. Directed cases then use an off-window base, a wrong modifier and a wrong short address to tell a selected request from an unselected one, and they cover the sticky parity flag and the cacheable indication.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int SEG_W  = 2;
    localparam int CTRL_W = 8;

    typedef struct packed {
        logic             perr;
        logic             priv_all;
        logic [SEG_W-1:0] range;
        logic             berr_en;
        logic             nocache;
        logic             bad_par;
        logic             rep_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_MEM  = 2'd1,
        KIND_CSR  = 2'd2
    } req_kind_t;

    typedef enum logic [1:0] {
        VERD_IDLE  = 2'd0,
        VERD_GRANT = 2'd1,
        VERD_FAULT = 2'd2,
        VERD_DROP  = 2'd3
    } verdict_t;

    function automatic logic seg_is_private(ctrl_t c, logic [SEG_W-1:0] seg);
        return c.priv_all || (seg >= c.range);
    endfunction

    function automatic verdict_t judge(req_kind_t k, ctrl_t c, logic [SEG_W-1:0] seg);
        if (k != KIND_MEM)          return VERD_IDLE;
        if (!seg_is_private(c, seg)) return VERD_GRANT;
        if (c.berr_en)              return VERD_FAULT;
        return VERD_DROP;
    endfunction

endpackage

// File: rtl/spc_decode.sv
module spc_decode
    import spc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_LOG2 = 20,
    parameter int SHORT_W  = 16,
    parameter int AM_W     = 6,
    parameter logic [AM_W-1:0] CSR_AM = 6'h15
) (
    input  logic                     req,
    input  logic [AM_W-1:0]          am,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [ADDR_W-WIN_LOG2-1:0] base,
    input  logic [SHORT_W-1:0]       short_sel,
    output req_kind_t                kind,
    output logic [SEG_W-1:0]         seg
);
    localparam int SEG_LSB = WIN_LOG2 - SEG_W;

    logic win_hit;
    logic short_hit;

    always_comb begin
        win_hit   = (addr[ADDR_W-1:WIN_LOG2] == base);
        short_hit = (addr[SHORT_W-1:0] == short_sel);
        seg       = addr[SEG_LSB +: SEG_W];
        if (!req)
            kind = KIND_NONE;
        else if (am == CSR_AM)
            kind = short_hit ? KIND_CSR : KIND_NONE;
        else if (win_hit)
            kind = KIND_MEM;
        else
            kind = KIND_NONE;
    end

endmodule

// File: rtl/spc_csr.sv
module spc_csr
    import spc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              write,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              par_err_in,
    output ctrl_t             ctrl,
    output logic [CTRL_W-1:0] rdata,
    output logic              ack
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            rdata <= '0;
            ack   <= 1'b0;
        end else begin
            ack <= sel;
            if (sel && !write)
                rdata <= ctrl;
            if (sel && write)
                ctrl <= ctrl_t'(wdata);
            if (par_err_in)
                ctrl.perr <= 1'b1;
        end
    end

    // R2: acknowledge only after a selecting request
    a_r2_ack_after_select: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(sel));

    // R2: contents change only through a write or the parity flag
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sel && write) && !$past(par_err_in)) |-> $stable(ctrl));

    // R9: a parity error always leaves the flag set
    a_r9_perr_sets: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(par_err_in)) |-> ctrl.perr);

endmodule

// File: rtl/spc_gate.sv
module spc_gate
    import spc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  req_kind_t        kind,
    input  logic [SEG_W-1:0] seg,
    input  ctrl_t            ctrl,
    output logic             grant,
    output logic             berr
);
    verdict_t verdict;

    always_comb verdict = judge(kind, ctrl, seg);

    always_ff @(posedge clk) begin
        if (rst) begin
            grant <= 1'b0;
            berr  <= 1'b0;
        end else begin
            grant <= (verdict == VERD_GRANT);
            berr  <= (verdict == VERD_FAULT);
        end
    end

    // R6: never both answers at once
    a_r6_one_answer: assert property (@(posedge clk) disable iff (rst)
        !(grant && berr));

    // R3: private-all forbids a grant
    a_r3_no_grant_all_private: assert property (@(posedge clk) disable iff (rst)
        grant |-> !$past(ctrl.priv_all));

    // R4: a granted segment lies below the range value
    a_r4_grant_below_range: assert property (@(posedge clk) disable iff (rst)
        grant |-> ($past(seg) < $past(ctrl.range)));

    // R7: a bus error needs the enable bit
    a_r7_berr_needs_enable: assert property (@(posedge clk) disable iff (rst)
        berr |-> $past(ctrl.berr_en));

endmodule

// File: rtl/seg_privacy_ctrl.sv
module seg_privacy_ctrl
    import spc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_LOG2 = 20,
    parameter int SHORT_W  = 16,
    parameter int AM_W     = 6,
    parameter logic [AM_W-1:0] CSR_AM = 6'h15
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sys_req,
    input  logic [AM_W-1:0]              sys_am,
    input  logic [ADDR_W-1:0]            sys_addr,
    input  logic                         sys_write,
    input  logic [CTRL_W-1:0]            sys_wdata,
    input  logic [ADDR_W-WIN_LOG2-1:0]   win_base,
    input  logic [SHORT_W-1:0]           csr_addr,
    input  logic                         par_err_in,
    input  logic                         loc_ack,
    output logic                         sys_grant,
    output logic                         sys_berr,
    output logic                         csr_ack,
    output logic [CTRL_W-1:0]            csr_rdata,
    output logic                         wrong_par,
    output logic                         par_rep_en,
    output logic                         loc_cache_n
);
    req_kind_t        kind;
    logic [SEG_W-1:0] seg;
    ctrl_t            ctrl;

    spc_decode #(
        .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .SHORT_W(SHORT_W),
        .AM_W(AM_W), .CSR_AM(CSR_AM)
    ) u_decode (
        .req(sys_req), .am(sys_am), .addr(sys_addr), .base(win_base),
        .short_sel(csr_addr), .kind(kind), .seg(seg)
    );

    spc_csr u_csr (
        .clk(clk), .rst(rst), .sel(kind == KIND_CSR), .write(sys_write),
        .wdata(sys_wdata), .par_err_in(par_err_in), .ctrl(ctrl),
        .rdata(csr_rdata), .ack(csr_ack)
    );

    spc_gate u_gate (
        .clk(clk), .rst(rst), .kind(kind), .seg(seg), .ctrl(ctrl),
        .grant(sys_grant), .berr(sys_berr)
    );

    always_comb begin
        wrong_par   = ctrl.bad_par;
        par_rep_en  = ctrl.rep_en;
        loc_cache_n = !(loc_ack && !ctrl.nocache);
    end

    // R8: any answer traces back to an in-window memory request
    a_r8_answer_needs_mem: assert property (@(posedge clk) disable iff (rst)
        (sys_grant || sys_berr) |-> $past(kind == KIND_MEM));

    // R2: register and memory answers are never given together
    a_r2_csr_not_mem: assert property (@(posedge clk) disable iff (rst)
        csr_ack |-> !(sys_grant || sys_berr));

endmodule

// File: tb/seg_privacy_ctrl_tb_top.sv
module seg_privacy_ctrl_tb_top;

    localparam logic [11:0] BASE = 12'hA5C;
    localparam logic [15:0] REGA = 16'h0C40;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [1:0] seg;
        logic       g;
        logic       b;
    } vec_t;

    // R4 boundaries, R6/R7 error enable, R5 range ignored under private-all
    localparam vec_t VECS [13] = '{
        '{8'h00, 2'd0, 1'b0, 1'b0},
        '{8'h08, 2'd0, 1'b0, 1'b1},
        '{8'h18, 2'd0, 1'b1, 1'b0},
        '{8'h18, 2'd1, 1'b0, 1'b1},
        '{8'h28, 2'd1, 1'b1, 1'b0},
        '{8'h28, 2'd2, 1'b0, 1'b1},
        '{8'h38, 2'd2, 1'b1, 1'b0},
        '{8'h38, 2'd3, 1'b0, 1'b1},
        '{8'h30, 2'd3, 1'b0, 1'b0},
        '{8'h78, 2'd0, 1'b0, 1'b1},
        '{8'h70, 2'd2, 1'b0, 1'b0},
        '{8'h48, 2'd3, 1'b0, 1'b1},
        '{8'h34, 2'd1, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sys_req = 1'b0;
    logic [5:0]  sys_am = 6'h39;
    logic [31:0] sys_addr = '0;
    logic        sys_write = 1'b0;
    logic [7:0]  sys_wdata = '0;
    logic        par_err_in = 1'b0;
    logic        loc_ack = 1'b0;
    logic        sys_grant, sys_berr, csr_ack, wrong_par, par_rep_en, loc_cache_n;
    logic [7:0]  csr_rdata;

    int checks = 0;
    int fails  = 0;
    logic got_g, got_b, got_ack;
    logic [7:0] got_rd;

    always #2 clk = ~clk;

    seg_privacy_ctrl dut_i (
        .clk(clk), .rst(rst), .sys_req(sys_req), .sys_am(sys_am),
        .sys_addr(sys_addr), .sys_write(sys_write), .sys_wdata(sys_wdata),
        .win_base(BASE), .csr_addr(REGA), .par_err_in(par_err_in),
        .loc_ack(loc_ack), .sys_grant(sys_grant), .sys_berr(sys_berr),
        .csr_ack(csr_ack), .csr_rdata(csr_rdata), .wrong_par(wrong_par),
        .par_rep_en(par_rep_en), .loc_cache_n(loc_cache_n)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic bus(input logic [5:0] am, input logic [31:0] a,
                       input logic we, input logic [7:0] wd);
        @(negedge clk);
        sys_am = am; sys_addr = a; sys_write = we; sys_wdata = wd; sys_req = 1'b1;
        @(negedge clk);
        sys_req = 1'b0;
        got_g = sys_grant; got_b = sys_berr; got_ack = csr_ack; got_rd = csr_rdata;
    endtask

    task automatic csr_wr(input logic [7:0] v);
        bus(6'h15, {16'h0, REGA}, 1'b1, v);
    endtask

    task automatic csr_rd(output logic [7:0] v);
        bus(6'h15, {16'h0, REGA}, 1'b0, 8'h00);
        v = got_rd;
    endtask

    task automatic mem(input logic [11:0] b, input logic [1:0] s);
        bus(6'h39, {b, s, 18'h00ABC}, 1'b0, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        csr_rd(rd);
        check("R1", "reset value", rd, 8'h00);
        mem(BASE, 2'd2);
        check("R1", "grant after reset", got_g, 1'b0);
        check("R1", "berr after reset", got_b, 1'b0);

        // R4 R5 R6 R7: table walk
        foreach (VECS[i]) begin
            csr_wr(VECS[i].ctrl);
            mem(BASE, VECS[i].seg);
            check("R4/R5", $sformatf("grant row %0d", i), got_g, VECS[i].g);
            check("R6/R7", $sformatf("berr row %0d", i), got_b, VECS[i].b);
        end

        // R3: private-all blocks the lowest segment too
        csr_wr(8'h78);
        mem(BASE, 2'd0);
        check("R3", "grant private-all", got_g, 1'b0);

        // R2: write, ack, read back
        csr_wr(8'h38);
        check("R2", "write ack", got_ack, 1'b1);
        csr_rd(rd);
        check("R2", "read ack", got_ack, 1'b1);
        check("R2", "read back", rd, 8'h38);
        bus(6'h2D, {16'h0, REGA}, 1'b1, 8'h55);
        check("R2", "wrong modifier ack", got_ack, 1'b0);
        bus(6'h15, {16'h0, REGA ^ 16'h0001}, 1'b1, 8'h55);
        check("R2", "wrong address ack", got_ack, 1'b0);
        csr_rd(rd);
        check("R2", "unselected writes ignored", rd, 8'h38);

        // R8: off-window and register-modifier requests get no answer
        mem(BASE ^ 12'h001, 2'd0);
        check("R8", "off-window grant", got_g, 1'b0);
        check("R8", "off-window berr", got_b, 1'b0);
        bus(6'h15, {BASE, 2'd0, 18'h00ABC}, 1'b0, 8'h00);
        check("R8", "register modifier grant", got_g, 1'b0);
        mem(BASE, 2'd0);
        check("R8", "in-window control grant", got_g, 1'b1);

        // R9: sticky parity flag
        @(negedge clk); par_err_in = 1'b1;
        @(negedge clk); par_err_in = 1'b0;
        csr_rd(rd);
        check("R9", "flag set", rd, 8'hB8);
        csr_wr(8'h38);
        csr_rd(rd);
        check("R9", "flag cleared", rd, 8'h38);
        csr_wr(8'hB8);
        csr_rd(rd);
        check("R9", "flag set by write", rd, 8'hB8);
        @(negedge clk);
        sys_am = 6'h15; sys_addr = {16'h0, REGA}; sys_write = 1'b1;
        sys_wdata = 8'h00; sys_req = 1'b1; par_err_in = 1'b1;
        @(negedge clk);
        sys_req = 1'b0; par_err_in = 1'b0;
        csr_rd(rd);
        check("R9", "flag wins over write", rd, 8'h80);

        // R10: cacheable indication
        csr_wr(8'h00);
        loc_ack = 1'b1; #1;
        check("R10", "cacheable low", loc_cache_n, 1'b0);
        loc_ack = 1'b0; #1;
        check("R10", "idle high", loc_cache_n, 1'b1);
        csr_wr(8'h04);
        loc_ack = 1'b1; #1;
        check("R10", "disabled high", loc_cache_n, 1'b1);
        loc_ack = 1'b0;

        // R11: diagnostic outputs
        csr_wr(8'h02); #1;
        check("R11", "wrong parity", wrong_par, 1'b1);
        check("R11", "report enable off", par_rep_en, 1'b0);
        csr_wr(8'h01); #1;
        check("R11", "wrong parity off", wrong_par, 1'b0);
        check("R11", "report enable", par_rep_en, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule